// File: doc/BRIEF.md
# Target Read Data-Phase Controller

This block runs the data phases of a bus-target read. Once the address of a read has been claimed, a start pulse loads the transfer address and the phase width. From then on, each cycle in which the bus master is waiting for a data phase, the controller picks one of four actions. It can present a word and pop the prefetch FIFO, hold the phase with a wait state, answer with a retry, or disconnect. A disconnect either comes with the final word or comes without data.

The choice depends on four things: whether the FIFO holds data, a burst-pending mode bit, the master's last-cycle indication, and where the next address would fall. When burst-pending is off, a starved phase ends the transfer at once. When it is on, the controller waits up to eight cycles for data. A burst also ends before the next address would cross a base region, whose size is a power of two given as a log2 input, or a 2^18-byte page. Every termination comes with a one-cycle flush pulse, which drops unused prefetched words.

All outputs are registered. The response to the inputs sampled at one rising edge is visible during the following cycle.

Top module: `trd_phase_ctrl`

## Requirements
- R1: After reset, `busy` and every response output (`data_rdy`, `fifo_pop`, `retry`, `disc_data`, `disc_nodata`, `flush`) are 0.
- R2: `start` while idle latches `start_addr` and `wide` and sets `busy`. `start` while busy is ignored: the next presented address continues the running burst.
- R3: A requested phase with the FIFO non-empty raises `data_rdy` and `fifo_pop` for one cycle, with `xfer_addr` equal to the phase address. The address then advances by 4 (`wide`=0) or by 8 (`wide`=1).
- R4: A requested first phase that finds the FIFO empty with `burst_pend`=0 gives `retry` and `flush`, and the controller goes idle.
- R5: A requested later phase that finds the FIFO empty with `burst_pend`=0 gives `disc_nodata` and `flush`, and the controller goes idle.
- R6: With `burst_pend`=1, an empty requested phase is held as a wait state with no response, up to 8 consecutive times. A ninth empty phase terminates: `retry` on the first phase, `disc_nodata` otherwise. A presented word resets the wait count.
- R7: A presented phase with `last_cyc`=1 also raises `disc_data` and `flush`, and the controller goes idle.
- R8: A presented phase whose next address would change the address bits at and above `region_log2` is terminated with `disc_data` and `flush`.
- R9: A presented phase whose next address would change the address bits at and above bit 18 is terminated with `disc_data` and `flush`.
- R10: With `phase_req`=0, or while idle, no response output rises and the wait count does not advance.
- R11: At most one of `retry`, `disc_data` and `disc_nodata` is high in a cycle. `flush` is high exactly in those cycles, and `busy` is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a read transfer (taken only while idle) |
| start_addr | input | AW | Byte address of the first phase |
| wide | input | 1 | 1 = 8-byte phases, 0 = 4-byte phases; latched on start |
| burst_pend | input | 1 | 1 = hold starved phases with wait states |
| region_log2 | input | $clog2(AW) | log2 of the base region size in bytes |
| phase_req | input | 1 | Master is waiting for a data phase |
| fifo_empty | input | 1 | Prefetch FIFO holds no word |
| last_cyc | input | 1 | Master marks this phase as the final one |
| busy | output | 1 | A transfer is in progress |
| data_rdy | output | 1 | A word is presented this cycle |
| fifo_pop | output | 1 | Pop strobe to the prefetch FIFO |
| retry | output | 1 | First phase answered with retry |
| disc_data | output | 1 | Disconnect together with the presented word |
| disc_nodata | output | 1 | Disconnect with no word |
| flush | output | 1 | Drop remaining prefetched words |
| xfer_addr | output | AW | Address of the presented word |

## Verification
The block's main coincidence is a presented word that is also the final one. In that cycle `data_rdy` and `fifo_pop` rise together with `disc_data` and `flush`. The bench provokes this in three ways: a last-cycle mark, a phase just below a region boundary in wide mode, and a phase just below a 2^18-byte page edge. The scoreboard expects all four strobes in that one cycle and `busy` low in the next. A second coincidence is a word arriving after a run of wait states. The bench then expects the wait count to restart, so a further eight waits still end in `disc_nodata` and not earlier.

// File: rtl/trd_pkg.sv
package trd_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } trd_state_t;

  typedef struct packed {
    logic rdy;
    logic pop;
    logic retry;
    logic disc_data;
    logic disc_nodata;
    logic flush;
  } trd_resp_t;

endpackage

// File: rtl/trd_addr_step.sv
module trd_addr_step #(
  parameter int AW        = 32,
  parameter int PAGE_LOG2 = 18,
  parameter int RLW       = $clog2(AW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [AW-1:0]  load_addr,
  input  logic           load_wide,
  input  logic           adv,
  input  logic [RLW-1:0] region_log2,
  output logic [AW-1:0]  addr,
  output logic           crossing
);

  localparam logic [AW-1:0] STEP_NARROW = AW'(4);
  localparam logic [AW-1:0] STEP_WIDE   = AW'(8);

  logic          wide_q;
  logic [AW-1:0] next_addr;
  logic [AW-1:0] diff;

  assign next_addr = addr + (wide_q ? STEP_WIDE : STEP_NARROW);
  assign diff      = addr ^ next_addr;
  assign crossing  = ((diff >> region_log2) != '0) || ((diff >> PAGE_LOG2) != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      wide_q <= 1'b0;
    end else if (load) begin
      addr   <= load_addr;
      wide_q <= load_wide;
    end else if (adv) begin
      addr   <= next_addr;
    end
  end

endmodule

// File: rtl/trd_wait_timer.sv
module trd_wait_timer #(
  parameter int MAX_WAIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic expired
);

  localparam int CW = $clog2(MAX_WAIT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_WAIT);

  logic [CW-1:0] cnt;

  assign expired = (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick && !expired) cnt <= cnt + 1'b1;
  end

  // R6: wait count never exceeds its bound
  a_r6_wait_bounded: assert property (@(posedge clk) disable iff (rst) cnt <= LIMIT);

endmodule

// File: rtl/trd_phase_ctrl.sv
module trd_phase_ctrl
  import trd_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_WAIT  = 8,
  parameter int PAGE_LOG2 = 18,
  parameter int RLW       = $clog2(AW)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [AW-1:0]  start_addr,
  input  logic           wide,
  input  logic           burst_pend,
  input  logic [RLW-1:0] region_log2,
  input  logic           phase_req,
  input  logic           fifo_empty,
  input  logic           last_cyc,
  output logic           busy,
  output logic           data_rdy,
  output logic           fifo_pop,
  output logic           retry,
  output logic           disc_data,
  output logic           disc_nodata,
  output logic           flush,
  output logic [AW-1:0]  xfer_addr
);

  trd_state_t    state;
  logic          first_q;
  logic [AW-1:0] cur_addr;
  logic          crossing;
  logic          expired;

  logic start_ok, active, present, end_data, starve, hold, term_empty, term;
  trd_resp_t resp_d, resp_q;

  assign start_ok   = start && (state == ST_IDLE);
  assign active     = (state == ST_ACTIVE) && phase_req;
  assign present    = active && !fifo_empty;
  assign end_data   = present && (last_cyc || crossing);
  assign starve     = active && fifo_empty;
  assign hold       = starve && burst_pend && !expired;
  assign term_empty = starve && !hold;
  assign term       = end_data || term_empty;

  always_comb begin
    resp_d             = '0;
    resp_d.rdy         = present;
    resp_d.pop         = present;
    resp_d.disc_data   = end_data;
    resp_d.retry       = term_empty && first_q;
    resp_d.disc_nodata = term_empty && !first_q;
    resp_d.flush       = term;
  end

  trd_addr_step #(.AW(AW), .PAGE_LOG2(PAGE_LOG2), .RLW(RLW)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .load       (start_ok),
    .load_addr  (start_addr),
    .load_wide  (wide),
    .adv        (present),
    .region_log2(region_log2),
    .addr       (cur_addr),
    .crossing   (crossing)
  );

  trd_wait_timer #(.MAX_WAIT(MAX_WAIT)) u_wait (
    .clk    (clk),
    .rst    (rst),
    .clr    (start_ok || present || term),
    .tick   (hold),
    .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      first_q   <= 1'b0;
      resp_q    <= '0;
      xfer_addr <= '0;
    end else begin
      resp_q <= resp_d;
      if (present) xfer_addr <= cur_addr;
      if (start_ok) begin
        state   <= ST_ACTIVE;
        first_q <= 1'b1;
      end else if (term) begin
        state   <= ST_IDLE;
      end
      if (present) first_q <= 1'b0;
    end
  end

  assign busy        = (state == ST_ACTIVE);
  assign data_rdy    = resp_q.rdy;
  assign fifo_pop    = resp_q.pop;
  assign retry       = resp_q.retry;
  assign disc_data   = resp_q.disc_data;
  assign disc_nodata = resp_q.disc_nodata;
  assign flush       = resp_q.flush;

  // R11: one termination kind at a time
  a_r11_one_term: assert property (@(posedge clk) disable iff (rst)
    $onehot0({retry, disc_data, disc_nodata}));
  // R11: a flushed transfer is over
  a_r11_flush_ends: assert property (@(posedge clk) disable iff (rst) flush |-> !busy);
  // R7: a data disconnect carries a word
  a_r7_disc_has_word: assert property (@(posedge clk) disable iff (rst)
    disc_data |-> (data_rdy && fifo_pop));
  // R4: retry only answers a first phase
  a_r4_retry_first: assert property (@(posedge clk) disable iff (rst) retry |-> $past(first_q));
  // R10: an idle controller stays silent
  a_r10_idle_silent: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> !(data_rdy || retry || disc_nodata || flush));

endmodule

// File: tb/tb_trd_phase_ctrl.sv
module tb_trd_phase_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          wide = 1'b0;
  logic          burst_pend = 1'b0;
  logic [4:0]    region_log2 = 5'd12;
  logic          phase_req = 1'b0;
  logic          fifo_empty = 1'b1;
  logic          last_cyc = 1'b0;
  logic          busy, data_rdy, fifo_pop, retry, disc_data, disc_nodata, flush;
  logic [AW-1:0] xfer_addr;

  // staged configuration, applied together with the next step
  logic       nx_wide = 1'b0;
  logic       nx_bp = 1'b0;
  logic [4:0] nx_rl = 5'd12;

  int total = 0;
  int bad = 0;

  typedef struct {
    bit rdy; bit rt; bit dd; bit dn; bit bsy;
    logic [AW-1:0] addr;
    string tag;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  trd_phase_ctrl dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .wide(wide),
    .burst_pend(burst_pend), .region_log2(region_log2), .phase_req(phase_req),
    .fifo_empty(fifo_empty), .last_cyc(last_cyc), .busy(busy), .data_rdy(data_rdy),
    .fifo_pop(fifo_pop), .retry(retry), .disc_data(disc_data), .disc_nodata(disc_nodata),
    .flush(flush), .xfer_addr(xfer_addr)
  );

  function automatic exp_t mk(bit r, bit t, bit d, bit n, bit b, logic [AW-1:0] a, string tg);
    exp_t e;
    e.rdy = r; e.rt = t; e.dd = d; e.dn = n; e.bsy = b; e.addr = a; e.tag = tg;
    return e;
  endfunction

  task automatic step(bit st, logic [AW-1:0] sa, bit req, bit emp, bit lst, exp_t e);
    @(negedge clk);
    start = st; start_addr = sa; phase_req = req; fifo_empty = emp; last_cyc = lst;
    wide = nx_wide; burst_pend = nx_bp; region_log2 = nx_rl;
    q.push_back(e);
  endtask

  task automatic chk(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // monitor: compares each cycle's registered response
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "data_rdy", AW'(data_rdy), AW'(e.rdy));
        chk(e.tag, "fifo_pop", AW'(fifo_pop), AW'(e.rdy));
        chk(e.tag, "retry", AW'(retry), AW'(e.rt));
        chk(e.tag, "disc_data", AW'(disc_data), AW'(e.dd));
        chk(e.tag, "disc_nodata", AW'(disc_nodata), AW'(e.dn));
        chk(e.tag, "flush", AW'(flush), AW'(e.rt | e.dd | e.dn));
        chk(e.tag, "busy", AW'(busy), AW'(e.bsy));
        if (e.rdy) chk(e.tag, "xfer_addr", xfer_addr, e.addr);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1", "busy", AW'(busy), '0);
    chk("R1", "responses", AW'({data_rdy, fifo_pop, retry, disc_data, disc_nodata, flush}), '0);

    // R10: idle controller ignores requests
    step(0, 0, 1, 0, 1, mk(0,0,0,0,0,0,"R10_idle"));
    step(0, 0, 1, 1, 0, mk(0,0,0,0,0,0,"R10_idle"));

    // R3/R7 narrow burst ended by last_cyc
    step(1, 32'h100, 0, 1, 0, mk(0,0,0,0,1,0,"R2_start"));
    step(0, 0, 1, 0, 0, mk(1,0,0,0,1,32'h100,"R3_narrow"));
    step(0, 0, 1, 0, 0, mk(1,0,0,0,1,32'h104,"R3_narrow"));
    step(0, 0, 1, 0, 1, mk(1,0,1,0,0,32'h108,"R7_last"));

    // R4 first phase empty, no burst pending
    step(1, 32'h300, 0, 1, 0, mk(0,0,0,0,1,0,"R2_start"));
    step(0, 0, 1, 1, 0, mk(0,1,0,0,0,0,"R4_retry"));

    // R5 mid-burst empty, no burst pending
    step(1, 32'h200, 0, 1, 0, mk(0,0,0,0,1,0,"R2_start"));
    step(0, 0, 1, 0, 0, mk(1,0,0,0,1,32'h200,"R3_word"));
    step(0, 0, 1, 1, 0, mk(0,0,0,1,0,0,"R5_disc"));

    // R6 first phase: eight waits then retry
    nx_bp = 1'b1;
    step(1, 32'h400, 0, 1, 0, mk(0,0,0,0,1,0,"R2_start"));
    for (int i = 0; i < 8; i++) step(0, 0, 1, 1, 0, mk(0,0,0,0,1,0,"R6_wait_first"));
    step(0, 0, 1, 1, 0, mk(0,1,0,0,0,0,"R6_retry_after_waits"));

    // R6 mid-burst: waits, word resets count, eight waits, disconnect
    step(1, 32'h500, 0, 1, 0, mk(0,0,0,0,1,0,"R2_start"));
    step(0, 0, 1, 0, 0, mk(1,0,0,0,1,32'h500,"R6_word"));
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, mk(0,0,0,0,1,0,"R6_wait"));
    step(0, 0, 1, 0, 0, mk(1,0,0,0,1,32'h504,"R6_word_after_wait"));
    for (int i = 0; i < 8; i++) step(0, 0, 1, 1, 0, mk(0,0,0,0,1,0,"R6_wait_reset"));
    step(0, 0, 1, 1, 0, mk(0,0,0,1,0,0,"R6_disc_after_waits"));

    // R8 wide burst stopped at a 32-byte region
    nx_bp = 1'b0; nx_wide = 1'b1; nx_rl = 5'd5;
    step(1, 32'h0, 0, 1, 0, mk(0,0,0,0,1,0,"R2_start"));
    step(0, 0, 1, 0, 0, mk(1,0,0,0,1,32'h0,"R3_wide"));
    step(0, 0, 1, 0, 0, mk(1,0,0,0,1,32'h8,"R3_wide"));
    step(0, 0, 1, 0, 0, mk(1,0,0,0,1,32'h10,"R3_wide"));
    step(0, 0, 1, 0, 0, mk(1,0,1,0,0,32'h18,"R8_region"));
    nx_rl = 5'd4;
    step(1, 32'h8, 0, 1, 0, mk(0,0,0,0,1,0,"R2_start"));
    step(0, 0, 1, 0, 0, mk(1,0,1,0,0,32'h8,"R8_region_single"));

    // R9 page crossing at 2^18
    nx_wide = 1'b0; nx_rl = 5'd20;
    step(1, 32'h3FFF8, 0, 1, 0, mk(0,0,0,0,1,0,"R2_start"));
    step(0, 0, 1, 0, 0, mk(1,0,0,0,1,32'h3FFF8,"R9_page"));
    step(0, 0, 1, 0, 0, mk(1,0,1,0,0,32'h3FFFC,"R9_page"));

    // R10 / R2: no request means no waits; start while busy ignored
    nx_bp = 1'b1; nx_rl = 5'd12;
    step(1, 32'h600, 0, 1, 0, mk(0,0,0,0,1,0,"R2_start"));
    step(0, 0, 1, 0, 0, mk(1,0,0,0,1,32'h600,"R3_word"));
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1, 0, mk(0,0,0,0,1,0,"R10_no_req"));
    step(1, 32'h900, 0, 1, 0, mk(0,0,0,0,1,0,"R2_busy_start"));
    for (int i = 0; i < 5; i++) step(0, 0, 1, 1, 0, mk(0,0,0,0,1,0,"R10_wait_count"));
    step(0, 0, 1, 0, 0, mk(1,0,0,0,1,32'h604,"R2_ignored"));
    step(0, 0, 1, 0, 1, mk(1,0,1,0,0,32'h608,"R7_last"));
    step(0, 0, 0, 1, 0, mk(0,0,0,0,0,0,"R11_idle_after"));

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule